// File: doc/BRIEF.md
# Complementary Dead-Time Output Stage

This block sits between a PWM reference and a pair of output pins for one timer channel. From the single reference it produces a main output and a complementary output. On each edge of the reference, the output that is switching off drops at once. The output that is switching on waits for a programmable dead time, so the two never conduct together.

The dead time is set by an 8-bit code and a clock-division select. The code selects one of four regions, each with a coarser step than the one before it. The division select stretches each dead-time tick to 1, 2 or 4 clock cycles. Each output has its own polarity. A master enable, a latched break (from a pin or a software strobe) and two off-state selects decide whether the outputs run, take programmed idle levels, are held inactive or are released.

Top module: `deadtime_out_stage`

## Requirements
- R1: With both outputs enabled and running, a rising reference edge makes the complementary output inactive at the next clock edge. The main output becomes active L clock cycles after that edge, where L is the decoded tick count times the division factor. When L is 0, both change at that same edge.
- R2: With both outputs enabled and running, a falling reference edge makes the main output inactive at the next clock edge. The complementary output becomes active L clock cycles later, with L as in R1.
- R3: The code decodes to a tick count by region. With bit 7 clear, the count is the low 7 bits. With bits [7:6] = 10, it is (64 + bits[5:0]) × 2. With bits [7:5] = 110, it is (32 + bits[4:0]) × 8. With bits [7:5] = 111, it is (32 + bits[4:0]) × 16.
- R4: The division select maps 0 to ×1, 1 to ×2, and both 2 and 3 to ×4 clock cycles per tick.
- R5: A reference pulse that ends before its dead time has elapsed produces no pulse at all on the delayed output.
- R6: Each pin equals its logical activity XOR its polarity bit (polarity 1 means active low). This applies whenever the pin is driven.
- R7: The main and complementary outputs are never both active (driven at their active level) in the same cycle.
- R8: When only one output of the pair is enabled, that output follows the reference with no dead time, one clock edge late. The main output is active while the reference is high; the complementary output is active while it is low.
- R9: While running, a disabled output is driven to its inactive level when the run off-state select is 1. When that select is 0, the output is released (enable 0, pin 0).
- R10: While idle (master enable low or break held), with the idle off-state select at 1, both outputs are driven. If the idle-level select is 1, the main output is active and the complementary output is inactive; if it is 0, the reverse. A disabled output is driven inactive. With the idle off-state select at 0, both outputs are released.
- R11: The break input or the software break strobe forces the idle state in the same cycle. The idle state stays latched until a clock edge sees master enable low with no break request.
- R12: After reset, with master enable low and the idle off-state select at 0, both outputs are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | PWM reference from the compare logic |
| dtCode | input | 8 | Piecewise dead-time code |
| dtDiv | input | 2 | Dead-time clock division select |
| mainEn | input | 1 | Main output enable |
| compEn | input | 1 | Complementary output enable |
| mainPol | input | 1 | Main output polarity, 1 = active low |
| compPol | input | 1 | Complementary output polarity, 1 = active low |
| masterEn | input | 1 | Master output enable |
| offRun | input | 1 | Off-state select for disabled outputs while running |
| offIdle | input | 1 | Off-state select while idle |
| idleMainAct | input | 1 | Idle levels: 1 = main active, 0 = complementary active |
| breakIn | input | 1 | Break request pin, active high |
| swBreak | input | 1 | Software break strobe |
| mainOut | output | 1 | Main output pin level |
| mainOe | output | 1 | Main output drive enable |
| compOut | output | 1 | Complementary output pin level |
| compOe | output | 1 | Complementary output drive enable |

## Verification
The reference is registered once. The output that switches off therefore changes right after the first clock edge that sees the new reference level, and the delayed output follows exactly L cycles later; a single enabled output also follows after that one edge. Master enable, break and all the configuration selects act on the pins combinationally, in the same cycle. Releasing the break latch takes one edge with master enable low. The bench changes inputs 2 ns after a falling edge and counts falling edges after the change: the off-going output is checked at the first falling edge, the delayed output must first show at falling edge L+1, and combinational effects are checked 1 ns after the input change.

// File: rtl/dtstage_pkg.sv
package dtstage_pkg;
  localparam int CODE_W = 8;
  localparam int LEN_W  = 10;
  localparam int DIV_W  = 2;
  localparam int PRE_W  = 2;

  typedef struct packed {
    logic load;
    logic count;
  } dtStrobe_t;

  typedef enum logic [1:0] {
    ST_COMP_ON   = 2'd0,
    ST_MAIN_WAIT = 2'd1,
    ST_MAIN_ON   = 2'd2,
    ST_COMP_WAIT = 2'd3
  } dtState_t;

  // four-region code to tick count
  function automatic logic [LEN_W-1:0] decodeLen(input logic [CODE_W-1:0] code);
    logic [LEN_W-1:0] len;
    if (!code[7])      len = LEN_W'(code[6:0]);
    else if (!code[6]) len = LEN_W'({1'b1, code[5:0]}) << 1;
    else if (!code[5]) len = LEN_W'({1'b1, code[4:0]}) << 3;
    else               len = LEN_W'({1'b1, code[4:0]}) << 4;
    return len;
  endfunction
endpackage

// File: rtl/dtstage_datapath.sv
module dtstage_datapath
  import dtstage_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int LW = LEN_W,
  parameter int DW = DIV_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] dtCode,
  input  logic [DW-1:0] dtDiv,
  input  dtStrobe_t     strb,
  output logic          zeroLen,
  output logic          expire
);
  logic [LW-1:0] lenNow;
  logic [LW-1:0] cnt;
  logic [PW-1:0] pre;
  logic [PW-1:0] preLast;
  logic          tick;

  always_comb begin
    lenNow = decodeLen(dtCode);
    if (dtDiv == DW'(0))      preLast = '0;
    else if (dtDiv == DW'(1)) preLast = PW'(1);
    else                      preLast = PW'(3);
  end

  assign zeroLen = (lenNow == '0);
  assign tick    = (pre == preLast);
  assign expire  = strb.count && tick && (cnt == LW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre <= '0;
      cnt <= '0;
    end else if (strb.load) begin
      pre <= '0;
      cnt <= lenNow;
    end else if (strb.count && (cnt != '0)) begin
      if (tick) begin
        pre <= '0;
        cnt <= cnt - LW'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end
endmodule

// File: rtl/dtstage_ctrl.sv
module dtstage_ctrl
  import dtstage_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      refIn,
  input  logic      zeroLen,
  input  logic      expire,
  input  logic      mainEn,
  input  logic      compEn,
  input  logic      mainPol,
  input  logic      compPol,
  input  logic      masterEn,
  input  logic      offRun,
  input  logic      offIdle,
  input  logic      idleMainAct,
  input  logic      breakIn,
  input  logic      swBreak,
  output dtStrobe_t strb,
  output logic      brkHold,
  output logic      mainOut,
  output logic      mainOe,
  output logic      compOut,
  output logic      compOe
);
  dtState_t st, stNext;
  logic refQ;
  logic rise, fall;
  logic idleNow, bothEn, mainLog, compLog;

  assign rise = refIn && !refQ;
  assign fall = !refIn && refQ;

  always_comb begin
    stNext     = st;
    strb.load  = 1'b0;
    strb.count = (st == ST_MAIN_WAIT) || (st == ST_COMP_WAIT);
    if (rise) begin
      if (zeroLen) stNext = ST_MAIN_ON;
      else begin
        strb.load = 1'b1;
        stNext    = ST_MAIN_WAIT;
      end
    end else if (fall) begin
      if (zeroLen) stNext = ST_COMP_ON;
      else begin
        strb.load = 1'b1;
        stNext    = ST_COMP_WAIT;
      end
    end else if (expire) begin
      stNext = (st == ST_MAIN_WAIT) ? ST_MAIN_ON : ST_COMP_ON;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_COMP_ON;
      refQ    <= 1'b0;
      brkHold <= 1'b0;
    end else begin
      st   <= stNext;
      refQ <= refIn;
      if (breakIn || swBreak) brkHold <= 1'b1;
      else if (!masterEn)     brkHold <= 1'b0;
    end
  end

  assign idleNow = !masterEn || brkHold || breakIn || swBreak;
  assign bothEn  = mainEn && compEn;
  assign mainLog = bothEn ? (st == ST_MAIN_ON) : refQ;
  assign compLog = bothEn ? (st == ST_COMP_ON) : !refQ;

  always_comb begin
    mainOe  = 1'b0;
    mainOut = 1'b0;
    compOe  = 1'b0;
    compOut = 1'b0;
    if (!idleNow) begin
      if (mainEn) begin
        mainOe  = 1'b1;
        mainOut = mainLog ^ mainPol;
      end else if (offRun) begin
        mainOe  = 1'b1;
        mainOut = mainPol;
      end
      if (compEn) begin
        compOe  = 1'b1;
        compOut = compLog ^ compPol;
      end else if (offRun) begin
        compOe  = 1'b1;
        compOut = compPol;
      end
    end else if (offIdle) begin
      mainOe  = 1'b1;
      mainOut = (mainEn && idleMainAct) ^ mainPol;
      compOe  = 1'b1;
      compOut = (compEn && !idleMainAct) ^ compPol;
    end
  end
endmodule

// File: rtl/deadtime_out_stage.sv
module deadtime_out_stage
  import dtstage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic [CODE_W-1:0] dtCode,
  input  logic [DIV_W-1:0]  dtDiv,
  input  logic              mainEn,
  input  logic              compEn,
  input  logic              mainPol,
  input  logic              compPol,
  input  logic              masterEn,
  input  logic              offRun,
  input  logic              offIdle,
  input  logic              idleMainAct,
  input  logic              breakIn,
  input  logic              swBreak,
  output logic              mainOut,
  output logic              mainOe,
  output logic              compOut,
  output logic              compOe
);
  dtStrobe_t strb;
  logic      zeroLen;
  logic      expire;
  logic      brkHold;

  dtstage_datapath #(
    .CW(CODE_W), .LW(LEN_W), .DW(DIV_W), .PW(PRE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .dtCode(dtCode), .dtDiv(dtDiv),
    .strb(strb), .zeroLen(zeroLen), .expire(expire)
  );

  dtstage_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .refIn(refIn), .zeroLen(zeroLen), .expire(expire),
    .mainEn(mainEn), .compEn(compEn), .mainPol(mainPol), .compPol(compPol),
    .masterEn(masterEn), .offRun(offRun), .offIdle(offIdle),
    .idleMainAct(idleMainAct), .breakIn(breakIn), .swBreak(swBreak),
    .strb(strb), .brkHold(brkHold),
    .mainOut(mainOut), .mainOe(mainOe), .compOut(compOut), .compOe(compOe)
  );
endmodule

// File: rtl/deadtime_out_stage_chk.sv
module deadtime_out_stage_chk
  import dtstage_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] dtCode,
  input logic              mainEn,
  input logic              compEn,
  input logic              mainPol,
  input logic              compPol,
  input logic              masterEn,
  input logic              offRun,
  input logic              offIdle,
  input logic              idleMainAct,
  input logic              breakIn,
  input logic              swBreak,
  input logic              brkHold,
  input logic              mainOut,
  input logic              mainOe,
  input logic              compOut,
  input logic              compOe
);
  logic mainActive, compActive, running, pairRun;

  assign mainActive = mainOe && (mainOut != mainPol);
  assign compActive = compOe && (compOut != compPol);
  assign running    = masterEn && !brkHold && !breakIn && !swBreak;
  assign pairRun    = running && mainEn && compEn;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(mainActive && compActive)); // R7

  AST_MAIN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (pairRun && $past(pairRun) && (dtCode != '0) && $stable(dtCode) &&
     $stable(mainPol) && $stable(compPol) && $rose(mainActive))
    |-> !$past(compActive)); // R1

  AST_COMP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (pairRun && $past(pairRun) && (dtCode != '0) && $stable(dtCode) &&
     $stable(mainPol) && $stable(compPol) && $rose(compActive))
    |-> !$past(mainActive)); // R2

  AST_OFF_RUN_REL: assert property (@(posedge clk) disable iff (!rstN)
    (running && !mainEn && !offRun) |-> (!mainOe && !mainOut)); // R9

  AST_IDLE_REL: assert property (@(posedge clk) disable iff (!rstN)
    (!masterEn && !offIdle) |-> (!mainOe && !compOe && !mainOut && !compOut)); // R10

  AST_BREAK_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    ((breakIn || swBreak) && offIdle)
    |-> (mainOe && compOe && (mainActive == (mainEn && idleMainAct)))); // R11

  AST_BREAK_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(breakIn || swBreak)) |-> brkHold); // R11
endmodule

bind deadtime_out_stage deadtime_out_stage_chk chk_i (.*);

// File: tb/deadtime_out_stage_tb.sv
`timescale 1ns/1ps
module deadtime_out_stage_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic [7:0] dtCode = 8'd5;
  logic [1:0] dtDiv = 2'd0;
  logic mainEn = 1'b1, compEn = 1'b1, mainPol = 1'b0, compPol = 1'b0;
  logic masterEn = 1'b0, offRun = 1'b1, offIdle = 1'b0, idleMainAct = 1'b0;
  logic breakIn = 1'b0, swBreak = 1'b0;
  logic mainOut, mainOe, compOut, compOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  deadtime_out_stage dut_i (
    .clk(clk), .rstN(rstN), .refIn(refIn), .dtCode(dtCode), .dtDiv(dtDiv),
    .mainEn(mainEn), .compEn(compEn), .mainPol(mainPol), .compPol(compPol),
    .masterEn(masterEn), .offRun(offRun), .offIdle(offIdle),
    .idleMainAct(idleMainAct), .breakIn(breakIn), .swBreak(swBreak),
    .mainOut(mainOut), .mainOe(mainOe), .compOut(compOut), .compOe(compOe)
  );

  function automatic bit mainAct();
    return mainOe && (mainOut != mainPol);
  endfunction
  function automatic bit compAct();
    return compOe && (compOut != compPol);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic atDrive();
    @(negedge clk); #2;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a reference edge and time the delayed output
  task automatic measureEdge(input bit rising, input int gap, input string req);
    int seen = -1;
    int otherBad = 0;
    int overlap = 0;
    atDrive();
    refIn = rising;
    for (int k = 1; k <= gap + 3; k++) begin
      @(negedge clk);
      if (rising ? compAct() : mainAct()) otherBad++;
      if (mainAct() && compAct()) overlap++;
      if (seen < 0 && (rising ? mainAct() : compAct())) seen = k;
    end
    check(otherBad == 0, req, rising ? "comp active after rise" : "main active after fall",
          otherBad, 0);
    check(seen == gap + 1, req, rising ? "main on delay" : "comp on delay", seen - 1, gap);
    check(overlap == 0, "R7", "both active", overlap, 0);
  endtask

  task automatic t_reset();
    settle(1);
    check(!mainOe && !compOe && !mainOut && !compOut, "R12", "released after reset",
          {mainOe, compOe, mainOut, compOut}, 0);
  endtask

  task automatic t_run_start();
    atDrive();
    masterEn = 1'b1;
    #1;
    check(compAct() && !mainAct(), "R2", "comp active with low reference", compAct(), 1);
  endtask

  task automatic t_deadtime(input logic [7:0] code, input logic [1:0] div,
                            input int len, input string req);
    atDrive();
    dtCode = code;
    dtDiv  = div;
    measureEdge(1'b1, len, req);
    measureEdge(1'b0, len, req);
  endtask

  task automatic t_short();
    int mainSeen = 0;
    atDrive();
    dtCode = 8'd10;
    dtDiv  = 2'd0;
    atDrive();
    refIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (mainAct()) mainSeen++;
    end
    measureEdge(1'b0, 10, "R5");
    check(mainSeen == 0, "R5", "main pulse on short reference", mainSeen, 0);
  endtask

  task automatic t_polarity();
    atDrive();
    dtCode = 8'd3;
    refIn = 1'b1;
    settle(8);
    atDrive();
    mainPol = 1'b1;
    compPol = 1'b1;
    #1;
    check(mainOe && mainOut == 1'b0, "R6", "active-low main pin when active", mainOut, 0);
    check(compOe && compOut == 1'b1, "R6", "active-low comp pin when inactive", compOut, 1);
    atDrive();
    refIn = 1'b0;
    settle(8);
    check(mainOut == 1'b1 && compOut == 1'b0, "R6", "pins after fall",
          {mainOut, compOut}, 2'b10);
    atDrive();
    mainPol = 1'b0;
    compPol = 1'b0;
  endtask

  task automatic t_single();
    atDrive();
    dtCode = 8'd20;
    compEn = 1'b0;
    offRun = 1'b1;
    #1;
    check(compOe && compOut == 1'b0, "R9", "disabled comp driven inactive",
          {compOe, compOut}, 2'b10);
    atDrive();
    refIn = 1'b1;
    @(negedge clk);
    check(mainAct(), "R8", "lone main follows rise at first edge", mainAct(), 1);
    atDrive();
    offRun = 1'b0;
    #1;
    check(!compOe && !compOut, "R9", "disabled comp released", {compOe, compOut}, 0);
    atDrive();
    refIn = 1'b0;
    @(negedge clk);
    check(!mainAct(), "R8", "lone main follows fall at first edge", mainAct(), 0);
    atDrive();
    compEn = 1'b1;
    mainEn = 1'b0;
    offRun = 1'b1;
    #1;
    check(compAct(), "R8", "lone comp active with low reference", compAct(), 1);
    atDrive();
    refIn = 1'b1;
    @(negedge clk);
    check(!compAct() && mainOe && mainOut == 1'b0, "R8", "lone comp off after rise",
          compAct(), 0);
    atDrive();
    refIn = 1'b0;
    @(negedge clk);
    check(compAct(), "R8", "lone comp on after fall", compAct(), 1);
    atDrive();
    mainEn = 1'b1;
    settle(25);
  endtask

  task automatic t_idle();
    atDrive();
    dtCode = 8'd4;
    refIn = 1'b1;
    settle(8);
    atDrive();
    masterEn = 1'b0;
    offIdle = 1'b1;
    idleMainAct = 1'b0;
    #1;
    check(compAct() && !mainAct() && mainOe, "R10", "idle comp-active levels",
          {mainAct(), compAct()}, 2'b01);
    atDrive();
    idleMainAct = 1'b1;
    #1;
    check(mainAct() && !compAct() && compOe, "R10", "idle main-active levels",
          {mainAct(), compAct()}, 2'b10);
    atDrive();
    mainEn = 1'b0;
    #1;
    check(mainOe && mainOut == mainPol, "R10", "idle disabled main inactive",
          {mainOe, mainOut}, 2'b10);
    atDrive();
    mainEn = 1'b1;
    offIdle = 1'b0;
    #1;
    check(!mainOe && !compOe && !mainOut && !compOut, "R10", "idle released",
          {mainOe, compOe}, 0);
    atDrive();
    masterEn = 1'b1;
    #1;
    check(mainAct() && !compAct(), "R10", "run resumes after idle", mainAct(), 1);
  endtask

  task automatic t_break(input bit useSw);
    atDrive();
    offIdle = 1'b1;
    idleMainAct = 1'b0;
    atDrive();
    if (useSw) swBreak = 1'b1; else breakIn = 1'b1;
    #1;
    check(compAct() && !mainAct(), "R11", "break forces idle same cycle",
          {mainAct(), compAct()}, 2'b01);
    atDrive();
    swBreak = 1'b0;
    breakIn = 1'b0;
    settle(3);
    check(compAct() && !mainAct(), "R11", "break latched after request ends",
          {mainAct(), compAct()}, 2'b01);
    atDrive();
    masterEn = 1'b0;
    atDrive();
    masterEn = 1'b1;
    #1;
    check(mainAct() && !compAct(), "R11", "run after master enable cycle",
          {mainAct(), compAct()}, 2'b10);
  endtask

  initial begin
    settle(5);
    #2 rstN = 1'b1;
    t_reset();
    t_run_start();
    t_deadtime(8'h05, 2'd0, 5,    "R1 R3 low region");
    t_deadtime(8'h00, 2'd0, 0,    "R1 R3 zero code");
    t_deadtime(8'h7F, 2'd0, 127,  "R1 R3 low region top");
    t_deadtime(8'h85, 2'd0, 138,  "R1 R3 region x2");
    t_deadtime(8'hC3, 2'd0, 280,  "R1 R3 region x8");
    t_deadtime(8'hE1, 2'd0, 528,  "R1 R3 region x16");
    t_deadtime(8'h05, 2'd1, 10,   "R2 R4 div2");
    t_deadtime(8'h0A, 2'd2, 40,   "R2 R4 div4");
    t_deadtime(8'h0A, 2'd3, 40,   "R2 R4 select 3");
    t_deadtime(8'hFF, 2'd2, 4032, "R2 R3 R4 max");
    t_short();
    t_polarity();
    t_single();
    t_idle();
    t_break(1'b0);
    t_break(1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule